// File: doc/BRIEF.md
# Convolution Multiply-Accumulate Engine

This engine computes a convolution layer one output neuron at a time. For each neuron it walks every input map in the neuron's channel group and every position of a K×K window. It multiplies each activation by its weight and sums the products in a 32-bit accumulator. When the sum is complete, it shifts the sum right, clamps negative values to zero and saturates the result to 16 bits. Activations and weights are read from on-chip buffers through address ports. Each buffer returns data one cycle after the address is presented.

The layer shape is taken at a start pulse and held for the whole run. The shape covers the input and output map counts, the input and output dimensions, the kernel size, the stride, a two-group split flag and the output shift. One engine can therefore serve every convolution layer of a network. Results leave on a valid/ready stream. A full output register stalls the whole pipeline. The done flag rises once the last neuron of the layer has been taken downstream.

Top module: `conv_mac_engine`

## Requirements
- R1: Each output neuron (fo, oy, ox) equals the sum, over local input maps fl < C, ky < K and kx < K, of wt[((fo*C+fl)*K+ky)*K+kx] × act[((g+fl)*H+oy*S+ky)*W+ox*S+kx]. Here W and H are the input width and height, S is the stride and K is the kernel size. C is the number of input maps per group. g is the input base of fo's group. Both buffers return data one cycle after the address.
- R2: Weights are signed 8-bit and activations are signed 16-bit two's complement. Their products are sign-extended into a signed 32-bit accumulator.
- R3: The accumulated sum is arithmetically shifted right by the 5-bit shift setting. It is then limited to the range 0..32767, so any value above 32767 leaves as 32767.
- R4: A shifted sum below zero leaves as 0.
- R5: Results leave in order of output map, then output row, then output column.
- R6: The stride setting S (1 to 7) steps the window origin by S input pixels per output pixel, in both directions.
- R7: With the split flag clear, C equals the input map count and g = 0. With it set, C is half the input map count. Output maps below half the output count use g = 0, and the rest use g = C.
- R8: While out_valid_o is high and out_ready_i is low, the output data holds. No result is lost or repeated, whatever pattern out_ready_i follows.
- R9: A start pulse while busy_o is low latches every configuration input. A start pulse while busy and configuration changes after the start have no effect on the results.
- R10: done_o rises in the cycle after the final result is accepted, together with busy_o falling. It stays high until the next accepted start.
- R11: After reset, out_valid_o, busy_o and done_o are low.
- R12: Kernel sizes 1 to 11 and up to 512 input maps are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches the configuration when idle |
| cfg_in_maps_i | input | 10 | Input map count |
| cfg_out_maps_i | input | 10 | Output map count |
| cfg_in_w_i | input | 8 | Input width |
| cfg_in_h_i | input | 8 | Input height |
| cfg_out_w_i | input | 8 | Output width |
| cfg_out_h_i | input | 8 | Output height |
| cfg_kernel_i | input | 4 | Kernel size K (1..11) |
| cfg_stride_i | input | 3 | Stride S (1..7) |
| cfg_split_i | input | 1 | Two-group channel split |
| cfg_shift_i | input | 5 | Arithmetic right shift applied before output |
| act_addr_o | output | 20 | Activation buffer read address |
| act_data_i | input | 16 | Activation read data, one cycle after address |
| wt_addr_o | output | 20 | Weight buffer read address |
| wt_data_i | input | 8 | Weight read data, one cycle after address |
| out_data_o | output | 16 | Rectified, saturated result |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream ready |
| busy_o | output | 1 | Layer in progress |
| done_o | output | 1 | Layer finished |

## Verification
The engine issues one term per unstalled cycle. The data for that term returns one cycle after its address. The last term of a neuron is registered into the output at the next edge, so a neuron's result is due two edges after its final address, and the first result appears C·K·K+1 cycles after the start edge. Because stalls shift every result by a varying amount, the bench does not wait fixed cycle counts. It places the reference results in a queue in the R5 order and compares the head of the queue on each negative edge where valid and ready are both high, which is the edge before the transfer. done_o and busy_o are checked on the negative edge after done_o rises, and the queue must be empty by then.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int MAPS_W = 10;
  localparam int DIM_W  = 8;
  localparam int KER_W  = 4;
  localparam int STR_W  = 3;
  localparam int SHF_W  = 5;

  typedef struct packed {
    logic [MAPS_W-1:0] in_maps;
    logic [MAPS_W-1:0] out_maps;
    logic [DIM_W-1:0]  in_w;
    logic [DIM_W-1:0]  in_h;
    logic [DIM_W-1:0]  out_w;
    logic [DIM_W-1:0]  out_h;
    logic [KER_W-1:0]  kernel;
    logic [STR_W-1:0]  stride;
    logic              split;
    logic [SHF_W-1:0]  shift;
  } conv_cfg_t;
endpackage

// File: rtl/conv_addr_gen.sv
module conv_addr_gen
  import conv_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int WADDR_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               en_i,
  input  conv_cfg_t          cfg_i,
  output logic [ADDR_W-1:0]  act_addr_o,
  output logic [WADDR_W-1:0] wt_addr_o,
  output logic               term_valid_o,
  output logic               term_first_o,
  output logic               term_last_o,
  output logic               term_final_o
);
  logic              active_q;
  logic [MAPS_W-1:0] fo_q, fi_q;
  logic [DIM_W-1:0]  oy_q, ox_q;
  logic [KER_W-1:0]  ky_q, kx_q;

  logic [MAPS_W-1:0] cin_g;
  logic grp_hi, kx_last, ky_last, fi_last, ox_last, oy_last, fo_last;

  always_comb begin
    cin_g   = cfg_i.split ? (cfg_i.in_maps >> 1) : cfg_i.in_maps;
    grp_hi  = cfg_i.split && (fo_q >= (cfg_i.out_maps >> 1));
    kx_last = (kx_q == cfg_i.kernel - KER_W'(1));
    ky_last = (ky_q == cfg_i.kernel - KER_W'(1));
    fi_last = (fi_q == cin_g - MAPS_W'(1));
    ox_last = (ox_q == cfg_i.out_w - DIM_W'(1));
    oy_last = (oy_q == cfg_i.out_h - DIM_W'(1));
    fo_last = (fo_q == cfg_i.out_maps - MAPS_W'(1));
  end

  // innermost kx, then ky, then input map, then output pixel, then output map
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fo_q <= '0; fi_q <= '0; oy_q <= '0; ox_q <= '0; ky_q <= '0; kx_q <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      fo_q <= '0; fi_q <= '0; oy_q <= '0; ox_q <= '0; ky_q <= '0; kx_q <= '0;
    end else if (active_q && en_i) begin
      if (!kx_last) kx_q <= kx_q + KER_W'(1);
      else begin
        kx_q <= '0;
        if (!ky_last) ky_q <= ky_q + KER_W'(1);
        else begin
          ky_q <= '0;
          if (!fi_last) fi_q <= fi_q + MAPS_W'(1);
          else begin
            fi_q <= '0;
            if (!ox_last) ox_q <= ox_q + DIM_W'(1);
            else begin
              ox_q <= '0;
              if (!oy_last) oy_q <= oy_q + DIM_W'(1);
              else begin
                oy_q <= '0;
                if (!fo_last) fo_q <= fo_q + MAPS_W'(1);
                else          active_q <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  logic [ADDR_W-1:0]  fi_abs, iy, ix;
  logic [WADDR_W-1:0] wrow;

  always_comb begin
    fi_abs     = ADDR_W'(fi_q) + (grp_hi ? ADDR_W'(cin_g) : '0);
    iy         = ADDR_W'(oy_q) * ADDR_W'(cfg_i.stride) + ADDR_W'(ky_q);
    ix         = ADDR_W'(ox_q) * ADDR_W'(cfg_i.stride) + ADDR_W'(kx_q);
    act_addr_o = (fi_abs * ADDR_W'(cfg_i.in_h) + iy) * ADDR_W'(cfg_i.in_w) + ix;
    wrow       = (WADDR_W'(fo_q) * WADDR_W'(cin_g) + WADDR_W'(fi_q)) * WADDR_W'(cfg_i.kernel)
                 + WADDR_W'(ky_q);
    wt_addr_o  = wrow * WADDR_W'(cfg_i.kernel) + WADDR_W'(kx_q);
  end

  assign term_valid_o = active_q;
  assign term_first_o = (fi_q == '0) && (ky_q == '0) && (kx_q == '0);
  assign term_last_o  = fi_last && ky_last && kx_last;
  assign term_final_o = term_last_o && ox_last && oy_last && fo_last;

  // R1
  act_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> act_addr_o < ADDR_W'(cfg_i.in_maps) * ADDR_W'(cfg_i.in_h) * ADDR_W'(cfg_i.in_w));
endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
  parameter int ACT_W = 16,
  parameter int WT_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    term_valid_i,
  input  logic                    term_first_i,
  input  logic                    term_last_i,
  input  logic                    term_final_i,
  input  logic signed [ACT_W-1:0] act_data_i,
  input  logic signed [WT_W-1:0]  wt_data_i,
  output logic                    res_valid_o,
  output logic                    res_final_o,
  output logic signed [ACC_W-1:0] res_sum_o
);
  localparam int PROD_W = ACT_W + WT_W;

  logic valid_q, first_q, last_q, final_q, en_q;
  logic signed [ACT_W-1:0] act_hold_q;
  logic signed [WT_W-1:0]  wt_hold_q;
  logic signed [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0; first_q <= 1'b0; last_q <= 1'b0; final_q <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      en_q <= en_i;
      if (en_i) begin
        valid_q <= term_valid_i;
        first_q <= term_first_i;
        last_q  <= term_last_i;
        final_q <= term_final_i;
      end
    end
  end

  // buffer data belongs to the held term only in the first stalled cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_hold_q <= '0;
      wt_hold_q  <= '0;
    end else if (en_q) begin
      act_hold_q <= act_data_i;
      wt_hold_q  <= wt_data_i;
    end
  end

  logic signed [ACT_W-1:0]  act_use;
  logic signed [WT_W-1:0]   wt_use;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum;

  always_comb begin
    act_use = en_q ? act_data_i : act_hold_q;
    wt_use  = en_q ? wt_data_i  : wt_hold_q;
    prod    = act_use * wt_use;
    sum     = (first_q ? '0 : acc_q) + ACC_W'(prod);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (en_i && valid_q)   acc_q <= sum;
  end

  assign res_valid_o = en_i && valid_q && last_q;
  assign res_final_o = final_q;
  assign res_sum_o   = sum;
endmodule

// File: rtl/conv_out_stage.sv
module conv_out_stage #(
  parameter int ACT_W = 16,
  parameter int ACC_W = 32,
  parameter int SHF_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    res_valid_i,
  input  logic                    res_final_i,
  input  logic signed [ACC_W-1:0] res_sum_i,
  input  logic [SHF_W-1:0]        shift_i,
  input  logic                    out_ready_i,
  output logic [ACT_W-1:0]        out_data_o,
  output logic                    out_valid_o,
  output logic                    out_final_o
);
  logic signed [ACC_W-1:0] shifted;
  logic [ACT_W-1:0]        clipped;

  always_comb begin
    shifted = res_sum_i >>> shift_i;
    if (shifted[ACC_W-1])                  clipped = '0;
    else if (|shifted[ACC_W-2:ACT_W-1])    clipped = {1'b0, {(ACT_W-1){1'b1}}};
    else                                   clipped = shifted[ACT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_final_o <= 1'b0;
      out_data_o  <= '0;
    end else if (res_valid_i) begin
      out_valid_o <= 1'b1;
      out_final_o <= res_final_i;
      out_data_o  <= clipped;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R4
  relu_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !out_data_o[ACT_W-1]);
endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine
  import conv_pkg::*;
#(
  parameter int ACT_W   = 16,
  parameter int WT_W    = 8,
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 20,
  parameter int WADDR_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [MAPS_W-1:0]  cfg_in_maps_i,
  input  logic [MAPS_W-1:0]  cfg_out_maps_i,
  input  logic [DIM_W-1:0]   cfg_in_w_i,
  input  logic [DIM_W-1:0]   cfg_in_h_i,
  input  logic [DIM_W-1:0]   cfg_out_w_i,
  input  logic [DIM_W-1:0]   cfg_out_h_i,
  input  logic [KER_W-1:0]   cfg_kernel_i,
  input  logic [STR_W-1:0]   cfg_stride_i,
  input  logic               cfg_split_i,
  input  logic [SHF_W-1:0]   cfg_shift_i,
  output logic [ADDR_W-1:0]  act_addr_o,
  input  logic [ACT_W-1:0]   act_data_i,
  output logic [WADDR_W-1:0] wt_addr_o,
  input  logic [WT_W-1:0]    wt_data_i,
  output logic [ACT_W-1:0]   out_data_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               busy_o,
  output logic               done_o
);
  conv_cfg_t cfg_q;
  logic start_acc, en, out_final, fin_acc;
  logic term_valid, term_first, term_last, term_final;
  logic res_valid, res_final;
  logic signed [ACC_W-1:0] res_sum;

  assign start_acc = start_i && !busy_o;
  assign en        = !out_valid_o || out_ready_i;
  assign fin_acc   = out_valid_o && out_ready_i && out_final;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (start_acc) begin
      cfg_q  <= '{in_maps: cfg_in_maps_i, out_maps: cfg_out_maps_i,
                  in_w: cfg_in_w_i, in_h: cfg_in_h_i,
                  out_w: cfg_out_w_i, out_h: cfg_out_h_i,
                  kernel: cfg_kernel_i, stride: cfg_stride_i,
                  split: cfg_split_i, shift: cfg_shift_i};
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (fin_acc) begin
      busy_o <= 1'b0;
      done_o <= 1'b1;
    end
  end

  conv_addr_gen #(.ADDR_W(ADDR_W), .WADDR_W(WADDR_W)) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_acc),
    .en_i         (en),
    .cfg_i        (cfg_q),
    .act_addr_o   (act_addr_o),
    .wt_addr_o    (wt_addr_o),
    .term_valid_o (term_valid),
    .term_first_o (term_first),
    .term_last_o  (term_last),
    .term_final_o (term_final)
  );

  conv_mac #(.ACT_W(ACT_W), .WT_W(WT_W), .ACC_W(ACC_W)) u_mac (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .term_valid_i (term_valid),
    .term_first_i (term_first),
    .term_last_i  (term_last),
    .term_final_i (term_final),
    .act_data_i   (act_data_i),
    .wt_data_i    (wt_data_i),
    .res_valid_o  (res_valid),
    .res_final_o  (res_final),
    .res_sum_o    (res_sum)
  );

  conv_out_stage #(.ACT_W(ACT_W), .ACC_W(ACC_W), .SHF_W(SHF_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_valid_i (res_valid),
    .res_final_i (res_final),
    .res_sum_i   (res_sum),
    .shift_i     (cfg_q.shift),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_final_o (out_final)
  );

  // R10
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  cfg_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cfg_q));
  // R10
  done_after_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_acc |=> done_o && !busy_o);
endmodule

// File: tb/conv_mac_engine_bench.sv
module conv_mac_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [9:0]  in_maps = '0, out_maps = '0;
  logic [7:0]  in_w = '0, in_h = '0, out_w = '0, out_h = '0;
  logic [3:0]  kernel = '0;
  logic [2:0]  stride = '0;
  logic        split = 1'b0;
  logic [4:0]  shift = '0;
  logic [19:0] act_addr, wt_addr;
  logic [15:0] act_q;
  logic [7:0]  wt_q;
  logic [15:0] out_data;
  logic        out_valid, busy, done;
  logic        out_ready = 1'b1;

  conv_mac_engine u_conv_mac_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cfg_in_maps_i(in_maps), .cfg_out_maps_i(out_maps),
    .cfg_in_w_i(in_w), .cfg_in_h_i(in_h), .cfg_out_w_i(out_w), .cfg_out_h_i(out_h),
    .cfg_kernel_i(kernel), .cfg_stride_i(stride), .cfg_split_i(split), .cfg_shift_i(shift),
    .act_addr_o(act_addr), .act_data_i(act_q), .wt_addr_o(wt_addr), .wt_data_i(wt_q),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .busy_o(busy), .done_o(done)
  );

  logic signed [15:0] act_mem [4096];
  logic signed [7:0]  wt_mem  [4096];
  always @(posedge clk) begin
    act_q <= act_mem[act_addr[11:0]];
    wt_q  <= wt_mem[wt_addr[11:0]];
  end

  int    checks = 0, fails = 0;
  int    exp_q[$];
  string cur_tag = "R1";
  bit    bp_mode = 1'b0;

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: ready changes here; a transfer happens at the following posedge
  always @(negedge clk) begin
    out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check({cur_tag, " R9 unexpected result"}, int'(out_data), -1);
      else check({cur_tag, " R1 R5 data"}, int'(out_data), exp_q.pop_front());
    end
  end

  task automatic run_layer(input string tag, input int nin, input int nout, input int iw,
                           input int ih, input int k, input int s, input bit sp, input int sh,
                           input int amin, input int amax, input int wmin, input int wmax,
                           input bit bp, input bit poke);
    int ow, oh, cg, gb, acc, v;
    ow = (iw - k) / s + 1;
    oh = (ih - k) / s + 1;
    cg = sp ? nin / 2 : nin;
    for (int i = 0; i < 4096; i++) begin
      act_mem[i] = 16'(amin + int'($urandom_range(0, amax - amin)));
      wt_mem[i]  = 8'(wmin + int'($urandom_range(0, wmax - wmin)));
    end
    for (int fo = 0; fo < nout; fo++)
      for (int oy = 0; oy < oh; oy++)
        for (int ox = 0; ox < ow; ox++) begin
          gb  = (sp && fo >= nout / 2) ? cg : 0;
          acc = 0;
          for (int fl = 0; fl < cg; fl++)
            for (int ky = 0; ky < k; ky++)
              for (int kx = 0; kx < k; kx++)
                acc += int'(wt_mem[((fo * cg + fl) * k + ky) * k + kx]) *
                       int'(act_mem[((gb + fl) * ih + oy * s + ky) * iw + ox * s + kx]);
          v = acc >>> sh;
          if (v < 0) v = 0;
          if (v > 32767) v = 32767;
          exp_q.push_back(v);
        end
    cur_tag = tag;
    bp_mode = bp;
    @(negedge clk);
    in_maps = 10'(nin); out_maps = 10'(nout); in_w = 8'(iw); in_h = 8'(ih);
    out_w = 8'(ow); out_h = 8'(oh); kernel = 4'(k); stride = 3'(s); split = sp;
    shift = 5'(sh); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: config edits and a second start during the run must not matter
      in_maps = 10'd1; out_maps = 10'd1; kernel = 4'd1; shift = 5'd7;
      repeat (20) @(negedge clk);
      check("R9 busy during run", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check({tag, " R10 busy low at done"}, int'(busy), 0);
    check({tag, " R10 queue drained"}, exp_q.size(), 0);
    check({tag, " R10 done held"}, int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    check("R11 out_valid after reset", int'(out_valid), 0);
    check("R11 busy after reset", int'(busy), 0);
    check("R11 done after reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2 R4 R5: signed mixes, negative sums rectify to zero
    run_layer("R2 R4 basic", 2, 3, 5, 5, 3, 1, 1'b0, 0, -300, 300, -128, 127, 1'b0, 1'b0);
    // R6 R3: stride 2 with shift
    run_layer("R6 R3 stride2", 3, 2, 7, 7, 3, 2, 1'b0, 2, -1000, 1000, -60, 60, 1'b0, 1'b0);
    // R7: two groups
    run_layer("R7 grouped", 4, 4, 5, 5, 3, 1, 1'b1, 1, -500, 500, -100, 100, 1'b0, 1'b0);
    // R3: saturation to 32767
    run_layer("R3 saturate", 1, 2, 4, 4, 3, 1, 1'b0, 0, 20000, 32767, 100, 127, 1'b0, 1'b0);
    // R8: random backpressure
    run_layer("R8 backpressure", 2, 3, 6, 6, 3, 1, 1'b0, 3, -2000, 2000, -128, 127, 1'b1, 1'b0);
    // R12: largest kernel, stride 4
    run_layer("R12 k11", 1, 2, 15, 15, 11, 4, 1'b0, 6, -3000, 3000, -128, 127, 1'b1, 1'b0);
    // R12: 1x1 kernel
    run_layer("R12 k1", 3, 2, 4, 4, 1, 1, 1'b0, 0, -5000, 5000, -128, 127, 1'b0, 1'b0);
    // R9: start while busy and config edits ignored
    run_layer("R9 ignore", 2, 2, 6, 6, 3, 1, 1'b0, 1, -800, 800, -90, 90, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule